// File: doc/BRIEF.md
# Alternating-Polarity Parallel Prefix Adder

This block adds two 32-bit unsigned operands and returns a 32-bit sum with a carry-out. There is no carry-in. The carries come from a parallel prefix network. The network is built from explicit cell instances, and every cell is tied to a numbered stage. Each stage uses one signal polarity:

- **Pre-processing** gives each bit's generate and propagate in active-low form. Generate is the NAND of the two operand bits. Propagate is their XNOR.
- **Odd stages** use cells that accept active-low group terms and drive active-high results.
- **Even stages** use cells that accept active-high terms and drive active-low results.
- **Inversions** appear only on the few edges where the arriving polarity differs from what the receiving stage expects.

Each bit column ends in a generate-only cell, and that cell's output is the column's carry. A carry from an odd stage leaves in true form. A carry from an even stage leaves complemented. The sum stage combines the inverted propagate with each carry and corrects for the polarity in which that carry arrives.

The graph cuts the word into nine segments, with lengths of 1, 2, 3, 4, 5, 5, 4, 4 and 4 columns counting from bit 0. Within a segment, a serial chain of full cells forms the group terms for each column, starting from the segment's first column. A generate-only cell then merges each column's group term with the carry that leaves the previous segment.

By default the result passes through one output register with synchronous active-low reset. A build-time parameter removes this register and leaves the path purely combinational.

Top module: `pp_alt_adder`

## Requirements
- R1: With the output register present, `{cout, sum}` equals the 33-bit sum `a + b` of the operands sampled at the previous rising clock edge. This holds for every operand pair.
- R2: The carry into bit 0 is zero, so `sum[0]` equals `a[0] ^ b[0]`. For example, 0 + 0 gives sum 0 with cout 0. All-ones + 1 gives sum 0 with cout 1.
- R3: `cout` is the carry produced at bit 31. All-ones + all-ones gives cout 1 and sum 0xFFFFFFFE. 0x7FFFFFFF + 1 gives cout 0 and sum 0x80000000.
- R4: A carry generated at any bit position s travels correctly through a run of propagating bits from s up to any higher position. This holds for every start position and every run length.
- R5: While `rst_n` is low at a rising clock edge, the registered `sum` and `cout` become zero at that edge, regardless of the operands.
- R6: The prefix graph has 23 full (generate and propagate) cells and 31 generate-only cells, and its deepest carry leaves stage 9. No cell output feeds more than six cells.
- R7: Every sum bit is correct whether the carry into its column leaves an odd stage (true form) or an even stage (complemented). Alternating bit patterns produce the correct arithmetic result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| sum | output | 32 | Sum bits, registered by default |
| cout | output | 1 | Carry out of bit 31, registered by default |

## Verification
The hardest condition to reach from the ports is a carry that is born deep inside one segment and must cross several whole segments. Along the way it arrives at columns through cells of both polarities, and some of those edges need the single correcting inversion.

Random operands rarely form long propagate runs at a chosen origin. The stimulus therefore sweeps every pair of run start and run end: one operand holds ones from the start to the end, and the other holds a single one at the start. This places a carry on every possible path length into every column. Corner patterns and a long run of random pairs then cover general operands.

// File: rtl/pp_alt_pkg.sv
// Package pp_alt_pkg
// Describes the segmented prefix graph used by the adder and derives every
// structural figure from it: word width, segment start of each column, the
// stage at which each carry leaves the network, and the node counts.
// Assumes segment 0 holds exactly one column (bit 0), whose carry is the
// bit-0 generate itself.
package pp_alt_pkg;

    localparam int NSEG = 9;

    // Length of segment k, counted from bit 0 upward.
    function automatic int seg_len(input int k);
        case (k)
            0:       return 1;
            1:       return 2;
            2:       return 3;
            3:       return 4;
            4, 5:    return 5;
            default: return 4;
        endcase
    endfunction

    // Total adder width, the sum of all segment lengths.
    function automatic int total_width();
        int acc;
        acc = 0;
        for (int k = 0; k < NSEG; k++) acc += seg_len(k);
        return acc;
    endfunction

    localparam int ADD_W = total_width();

    // Lowest column of segment k.
    function automatic int seg_start(input int k);
        int acc;
        acc = 0;
        for (int m = 0; m < k; m++) acc += seg_len(m);
        return acc;
    endfunction

    // Segment holding column i.
    function automatic int seg_of(input int i);
        int acc;
        acc = 0;
        for (int k = 0; k < NSEG; k++) begin
            if (i < acc + seg_len(k)) return k;
            acc += seg_len(k);
        end
        return NSEG - 1;
    endfunction

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // Stage at which the carry leaving the top column of segment k is ready.
    function automatic int seg_depth(input int k);
        int d;
        d = 0;
        for (int m = 1; m <= k; m++) d = imax(seg_len(m) - 1, d) + 1;
        return d;
    endfunction

    // Stage at which the carry of column i is ready (0 = pre-processing).
    function automatic int carry_depth(input int i);
        int k;
        k = seg_of(i);
        if (k == 0) return 0;
        return imax(i - seg_start(k), seg_depth(k - 1)) + 1;
    endfunction

    // A value produced at stage d is active-low when d is even.
    function automatic bit low_at(input int d);
        return (d % 2) == 0;
    endfunction

    // Number of full cells (group generate and propagate).
    function automatic int dot_count();
        int acc;
        acc = 0;
        for (int k = 1; k < NSEG; k++) acc += seg_len(k) - 1;
        return acc;
    endfunction

    // Number of generate-only cells, one per column above bit 0.
    function automatic int semi_count();
        return ADD_W - 1;
    endfunction

    // Deepest stage of the whole network.
    function automatic int net_depth();
        int d;
        d = 0;
        for (int i = 0; i < ADD_W; i++) d = imax(d, carry_depth(i));
        return d;
    endfunction

    // Largest number of cells fed by one prefix-cell output or carry.
    function automatic int max_fanout();
        int f;
        f = 2;
        for (int k = 1; k < NSEG; k++) f = imax(f, seg_len(k));
        return f;
    endfunction

endpackage

// File: rtl/pp_pre.sv
// Module pp_pre
// Pre-processing: forms per-bit generate and propagate, both active-low.
// Generate is the NAND of the operand bits, propagate is their XNOR.
// Assumes nothing beyond equal operand widths.
module pp_pre #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] gen_n,
    output logic [W-1:0] prp_n
);
    // Bitwise inverted generate and propagate.
    always_comb begin
        gen_n = ~(a & b);
        prp_n = ~(a ^ b);
    end
endmodule

// File: rtl/pp_fix.sv
// Module pp_fix
// Edge adapter between a producing and a consuming prefix stage. When FLIP is
// set the edge carries the inverter pair that restores the polarity the
// consumer expects (one inversion in logic); otherwise it is a plain wire.
module pp_fix #(
    parameter int W    = 1,
    parameter bit FLIP = 1'b0
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    if (FLIP) begin : g_inv
        // Polarity-mismatched edge: invert.
        assign y = ~x;
    end else begin : g_pass
        // Matched edge: pass through.
        assign y = x;
    end
endmodule

// File: rtl/pp_dot.sv
// Module pp_dot
// Full prefix cell: combines a high group (g_hi, p_hi) with a low group
// (g_lo, p_lo) into (g_hi | p_hi & g_lo, p_hi & p_lo).
// ODD = 1: inputs active-low, outputs active-high (odd stage).
// ODD = 0: inputs active-high, outputs active-low (even stage).
module pp_dot #(
    parameter bit ODD = 1'b1
) (
    input  logic gh,
    input  logic ph,
    input  logic gl,
    input  logic pl,
    output logic go,
    output logic po
);
    if (ODD) begin : g_odd
        // Low-in, high-out form of the combine.
        assign go = ~(gh & (ph | gl));
        assign po = ~(ph | pl);
    end else begin : g_even
        // High-in, low-out form of the combine.
        assign go = ~(gh | (ph & gl));
        assign po = ~(ph & pl);
    end
endmodule

// File: rtl/pp_semi.sv
// Module pp_semi
// Generate-only prefix cell, the last node in a column: produces the column
// carry g_hi | p_hi & g_lo. Polarity convention as in pp_dot.
module pp_semi #(
    parameter bit ODD = 1'b1
) (
    input  logic gh,
    input  logic ph,
    input  logic gl,
    output logic go
);
    if (ODD) begin : g_odd
        // Low-in, high-out carry.
        assign go = ~(gh & (ph | gl));
    end else begin : g_even
        // High-in, low-out carry.
        assign go = ~(gh | (ph & gl));
    end
endmodule

// File: rtl/pp_net.sv
// Module pp_net
// Segmented prefix network. Inside each segment a serial chain of full cells
// forms the group term from the segment's first column to every column; a
// generate-only cell per column then merges it with the carry leaving the
// previous segment. Every cell sits at a stage fixed by pp_alt_pkg, and each
// input edge is adapted to that stage's polarity. car_raw holds each carry in
// the polarity of the stage that made it.
// Assumes active-low inputs from pp_pre and segment 0 of width one.
module pp_net
    import pp_alt_pkg::*;
#(
    parameter int W = ADD_W
) (
    input  logic [W-1:0] gen_n,
    input  logic [W-1:0] prp_n,
    output logic [W-1:0] car_raw
);
    logic [W-1:0] grp_g;
    logic [W-1:0] grp_p;

    for (genvar i = 0; i < W; i++) begin : g_col
        localparam int K  = seg_of(i);
        localparam int B  = seg_start(K);
        localparam int J  = i - B;
        localparam int T  = carry_depth(i);

        // Group term from the segment base to column i.
        if (J == 0) begin : g_base
            assign grp_g[i] = gen_n[i];
            assign grp_p[i] = prp_n[i];
        end else begin : g_chain
            localparam bit WANT_LOW = (J % 2) == 1;
            logic [1:0] hi_pair;
            logic [1:0] lo_pair;
            pp_fix #(.W(2), .FLIP(low_at(0) != WANT_LOW)) u_hi_fix (
                .x({gen_n[i], prp_n[i]}),
                .y(hi_pair)
            );
            pp_fix #(.W(2), .FLIP(low_at(J - 1) != WANT_LOW)) u_lo_fix (
                .x({grp_g[i-1], grp_p[i-1]}),
                .y(lo_pair)
            );
            pp_dot #(.ODD(WANT_LOW)) u_dot (
                .gh(hi_pair[1]),
                .ph(hi_pair[0]),
                .gl(lo_pair[1]),
                .pl(lo_pair[0]),
                .go(grp_g[i]),
                .po(grp_p[i])
            );
        end

        // Column carry.
        if (i == 0) begin : g_lsb
            assign car_raw[0] = gen_n[0];
        end else begin : g_merge
            localparam bit WANT_LOW = (T % 2) == 1;
            logic [1:0] hi_pair;
            logic       lo_g;
            pp_fix #(.W(2), .FLIP(low_at(J) != WANT_LOW)) u_hi_fix (
                .x({grp_g[i], grp_p[i]}),
                .y(hi_pair)
            );
            pp_fix #(.W(1), .FLIP(low_at(carry_depth(B - 1)) != WANT_LOW)) u_lo_fix (
                .x(car_raw[B-1]),
                .y(lo_g)
            );
            pp_semi #(.ODD(WANT_LOW)) u_semi (
                .gh(hi_pair[1]),
                .ph(hi_pair[0]),
                .gl(lo_g),
                .go(car_raw[i])
            );
        end
    end
endmodule

// File: rtl/pp_post.sv
// Module pp_post
// Post-processing: each sum bit is the inverted propagate of its column
// XORed with the carry from the column below, corrected for the polarity in
// which that carry left the network. Bit 0 sees a zero carry-in.
module pp_post
    import pp_alt_pkg::*;
#(
    parameter int W = ADD_W
) (
    input  logic [W-1:0] prp_n,
    input  logic [W-1:0] car_raw,
    output logic [W-1:0] sum,
    output logic         cout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            // No carry-in: sum is the true propagate.
            assign sum[0] = ~prp_n[0];
        end else if (low_at(carry_depth(i - 1))) begin : g_cmp
            // Complemented carry cancels the inverted propagate.
            assign sum[i] = prp_n[i] ^ car_raw[i-1];
        end else begin : g_true
            // True carry: restore the propagate polarity.
            assign sum[i] = ~(prp_n[i] ^ car_raw[i-1]);
        end
    end

    if (low_at(carry_depth(W - 1))) begin : g_cout_cmp
        // Top carry left an even stage.
        assign cout = ~car_raw[W-1];
    end else begin : g_cout_true
        // Top carry left an odd stage.
        assign cout = car_raw[W-1];
    end
endmodule

// File: rtl/pp_alt_adder.sv
// Module pp_alt_adder
// Top of the alternating-polarity prefix adder: pre-processing, prefix
// network and sum stage, followed by an optional output register with
// synchronous active-low reset (REG_OUT = 1). No carry-in.
// Assumes operands are held stable around the rising clock edge.
module pp_alt_adder
    import pp_alt_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADD_W-1:0] a,
    input  logic [ADD_W-1:0] b,
    output logic [ADD_W-1:0] sum,
    output logic             cout
);
    localparam int W = ADD_W;

    logic [W-1:0] gen_n;
    logic [W-1:0] prp_n;
    logic [W-1:0] car_raw;
    logic [W-1:0] sum_c;
    logic         cout_c;

    pp_pre #(.W(W)) u_pre (
        .a(a), .b(b), .gen_n(gen_n), .prp_n(prp_n)
    );

    pp_net #(.W(W)) u_net (
        .gen_n(gen_n), .prp_n(prp_n), .car_raw(car_raw)
    );

    pp_post #(.W(W)) u_post (
        .prp_n(prp_n), .car_raw(car_raw), .sum(sum_c), .cout(cout_c)
    );

    if (REG_OUT) begin : g_reg
        // Output register, cleared by synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum  <= '0;
                cout <= 1'b0;
            end else begin
                sum  <= sum_c;
                cout <= cout_c;
            end
        end

        // R1
        out_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> ({cout, sum} == $past({1'b0, a} + {1'b0, b})));

        // R5
        rst_clr_chk: assert property (@(posedge clk)
            !rst_n |=> (sum == '0 && !cout));
    end else begin : g_comb
        // Purely combinational result.
        assign sum  = sum_c;
        assign cout = cout_c;
    end

    // True-form carries, used only by the checks below.
    logic [W-1:0] c_true;
    for (genvar i = 0; i < W; i++) begin : g_ct
        if (low_at(carry_depth(i))) begin : g_n
            assign c_true[i] = ~car_raw[i];
        end else begin : g_p
            assign c_true[i] = car_raw[i];
        end
    end

    // R2
    carry_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_true[0] == (a[0] & b[0]));

    // R4
    carry_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_true[W-1:1] == ((a[W-1:1] & b[W-1:1]) | ((a[W-1:1] ^ b[W-1:1]) & c_true[W-2:0])));

    // R7
    sum_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_c == (a ^ b ^ {c_true[W-2:0], 1'b0}));

    // R3
    cout_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cout_c == c_true[W-1]);
endmodule

// File: tb/pp_alt_adder_test.sv
// Bench for pp_alt_adder (registered output). Inputs change on the falling
// edge; each result is sampled on the following falling edge.
module pp_alt_adder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [31:0] sum;
    logic        cout;

    int          total = 0;
    int          bad = 0;
    logic        pend = 1'b0;
    logic [32:0] exp_q = '0;
    string       ptag = "";

    always #2 clk = ~clk;

    pp_alt_adder uut (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .sum(sum), .cout(cout)
    );

    task automatic check_out(input logic [32:0] e, input string tag);
        total++;
        if ({cout, sum} !== e) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, {cout, sum}, e);
        end
    endtask

    task automatic check_int(input int got, input int e, input string tag);
        total++;
        if (got != e) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, e);
        end
    endtask

    task automatic step(input logic [31:0] na, input logic [31:0] nb, input string tag);
        @(negedge clk);
        if (pend) check_out(exp_q, ptag);
        a     = na;
        b     = nb;
        exp_q = {1'b0, na} + {1'b0, nb};
        ptag  = tag;
        pend  = 1'b1;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        if (pend) check_out(exp_q, ptag);
        pend  = 1'b0;
        rst_n = 1'b0;
        a     = 32'hFFFF_FFFF;
        b     = 32'h0000_0001;
        @(negedge clk);
        check_out(33'h0, "R5 reset clears output");
        rst_n = 1'b1;
    endtask

    initial begin
        #(4 * 190000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] run;
        // R6 structure figures
        check_int(pp_alt_pkg::dot_count(), 23, "R6 full cell count");
        check_int(pp_alt_pkg::semi_count(), 31, "R6 generate-only cell count");
        check_int(pp_alt_pkg::net_depth(), 9, "R6 stage depth");
        total++;
        if (pp_alt_pkg::max_fanout() > 6) begin
            bad++;
            $display("FAIL R6 fan-out: got %0d expected <= 6", pp_alt_pkg::max_fanout());
        end

        // R5 reset state with nonzero operands applied
        a = 32'hFFFF_FFFF;
        b = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check_out(33'h0, "R5 output during reset");
        rst_n = 1'b1;

        // R2 no carry-in
        step(32'h0, 32'h0, "R2 zero plus zero");
        step(32'hFFFF_FFFF, 32'h1, "R2 ones plus one");
        step(32'h1, 32'hFFFF_FFFF, "R2 one plus ones");
        step(32'h0000_0001, 32'h0000_0000, "R2 bit0 only");

        // R3 carry-out
        step(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 ones plus ones");
        step(32'h8000_0000, 32'h8000_0000, "R3 top bits");
        step(32'h7FFF_FFFF, 32'h0000_0001, "R3 no carry-out");

        // R7 alternating patterns
        step(32'h5555_5555, 32'hAAAA_AAAA, "R7 55 plus AA");
        step(32'hAAAA_AAAA, 32'hAAAA_AAAA, "R7 AA plus AA");
        step(32'h5555_5555, 32'h5555_5555, "R7 55 plus 55");
        step(32'h3333_3333, 32'h3333_3333, "R7 33 plus 33");
        step(32'hCCCC_CCCC, 32'h6666_6666, "R7 CC plus 66");
        step(32'h1234_5678, ~32'h1234_5678, "R7 value plus complement");

        // R5 mid-run reset
        pulse_reset();

        // R4 every carry origin and run length
        for (int s = 0; s < 32; s++) begin
            for (int e = s; e < 32; e++) begin
                run = ((64'd1 << (e + 1)) - 64'd1) ^ ((64'd1 << s) - 64'd1);
                step(run[31:0], 32'd1 << s, "R4 carry run");
            end
        end

        // R1 random operands
        for (int n = 0; n < 100000; n++) begin
            step($urandom, $urandom, "R1 random pair");
        end

        @(negedge clk);
        if (pend) check_out(exp_q, ptag);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule